// File: doc/BRIEF.md
# Synchronized Trigger Window Controller

This block accepts two trigger lines, one that opens a window and one that closes it, that change with no fixed relation to the system clock. Each line is retimed through its own chain of flip-flops clocked by the single system clock. The design then looks for the active edge on each retimed line by comparing the newest retimed sample with the one before it.

A four-state sequencer turns those edges into a window. Its states are idle, arm, run and halt. It drives a registered `running` flag and two pulses, each one clock wide. One pulse marks the moment the window opens and the other marks the moment it closes. If both triggers fire in the same cycle, the close trigger takes precedence. Every register updates on the rising edge of `clk` only.

The window logic reacts a fixed number of cycles after the raw trigger changes. That number is set by the retiming depth. The system clock must run much faster than the triggers, which are expected near 100 kHz, so that no edge is lost.

Top module: `trig_window_ctrl`

## Requirements
- R1: Each trigger line passes through SYNC_DEPTH series flip-flops, with SYNC_DEPTH of at least 2 and a default of 2. The design uses only the last stage. A trigger change that is present at rising clock edge k shows up on `running` and on the pulses from edge k+SYNC_DEPTH, and not before.
- R2: While `rst` is high at a clock edge, every retiming stage, the edge history, the state and `running` are cleared. After reset, `running`, `start_pulse` and `stop_pulse` are all 0.
- R3: In the idle state, an active start edge without a stop edge opens the window. `start_pulse` is 1 for exactly one cycle, and `running` becomes 1 in that same cycle.
- R4: While the window is open, further start edges are ignored. They produce no `start_pulse` and `running` stays 1.
- R5: While the window is open, an active stop edge closes it. `stop_pulse` is 1 for exactly one cycle, and `running` is 0 from that same cycle onward.
- R6: In the idle state, a stop edge has no effect: `running` stays 0 and neither pulse fires.
- R7: When start and stop edges reach the sequencer in the same cycle, stop wins. In the idle state the window stays closed and no pulse fires. In the open window it closes.
- R8: The halt state lasts one cycle and always returns to idle, so a later start edge opens a new window.
- R9: With ACTIVE_RISE=1 (the default), only 0-to-1 transitions count as events. 1-to-0 transitions on either line have no effect.
- R10: `start_pulse` and `stop_pulse` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Asynchronous trigger that opens the window |
| stop_in | input | 1 | Asynchronous trigger that closes the window |
| running | output | 1 | Registered flag, 1 while the window is open |
| start_pulse | output | 1 | One-cycle pulse when the window opens |
| stop_pulse | output | 1 | One-cycle pulse when the window closes |

## Verification
The hardest case to reach from the ports is two edges arriving at the sequencer in the same cycle. The bench creates it by raising both raw lines at the same clock phase. Because both lines have retiming chains of equal depth, the two edges reach the sequencer together. A sweep then steps through every combination of start and stop rises, from both the idle and the open window, with varied idle gaps. After each step it compares `running` and the pulse counts with a model computed in the bench. Separate directed steps pin down the exact latency cycle and show that falling edges are ignored.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_HALT = 2'd3
  } win_state_t;

  // Active transition between the previous and the current retimed sample.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

  // The window counts as open in these states.
  function automatic logic is_open(input win_state_t s);
    return (s == ST_ARM) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage [DEPTH];

  // The first stage feeds only the second; only the last stage leaves.
  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= async_in;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= '0;
      else     stage[g] <= stage[g-1];
    end
  end

  assign sync_out = stage[DEPTH-1];

  initial begin
    a_depth_min_r1: assert (DEPTH >= 2);
  end

endmodule

// File: rtl/trig_edge.sv
module trig_edge #(
  parameter int   W    = 2,
  parameter logic RISE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic [W-1:0] hit
);
  import trig_pkg::*;

  logic [W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= level;
  end

  for (genvar g = 0; g < W; g++) begin : g_hit
    assign hit[g] = edge_hit(level[g], hist_q[g], RISE);
  end

endmodule

// File: rtl/trig_fsm.sv
module trig_fsm (
  input  logic clk,
  input  logic rst,
  input  logic start_edge,
  input  logic stop_edge,
  output logic running,
  output logic start_pulse,
  output logic stop_pulse
);
  import trig_pkg::*;

  win_state_t state_q, state_d;
  logic       running_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!stop_edge && start_edge) state_d = ST_ARM;
      ST_ARM:  state_d = stop_edge ? ST_HALT : ST_RUN;
      ST_RUN:  if (stop_edge) state_d = ST_HALT;
      ST_HALT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Single process owns both the state and the running flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      running_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      running_q <= is_open(state_d);
    end
  end

  assign running     = running_q;
  assign start_pulse = (state_q == ST_ARM);
  assign stop_pulse  = (state_q == ST_HALT);

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(start_pulse && stop_pulse));
  p_start_once_r3: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);
  p_open_with_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> running);
  p_hold_open_r4: assert property (@(posedge clk) disable iff (rst)
    (running && !stop_edge) |=> running);
  p_close_with_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !running);
  p_idle_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && stop_edge) |=> !running && !stop_pulse);
  p_stop_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && stop_edge && start_edge) |=> !start_pulse);
  p_halt_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> (state_q == ST_IDLE));

endmodule

// File: rtl/trig_window_ctrl.sv
module trig_window_ctrl #(
  parameter int   SYNC_DEPTH  = 2,
  parameter logic ACTIVE_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_in,
  input  logic stop_in,
  output logic running,
  output logic start_pulse,
  output logic stop_pulse
);

  localparam int NLINES = 2;
  localparam int IDX_START = 0;
  localparam int IDX_STOP  = 1;

  logic [NLINES-1:0] raw_lines, sync_lines, line_hit;
  logic              start_edge, stop_edge;

  assign raw_lines[IDX_START] = start_in;
  assign raw_lines[IDX_STOP]  = stop_in;

  trig_sync #(.W(NLINES), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_lines),
    .sync_out (sync_lines)
  );

  trig_edge #(.W(NLINES), .RISE(ACTIVE_RISE)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sync_lines),
    .hit   (line_hit)
  );

  assign start_edge = line_hit[IDX_START];
  assign stop_edge  = line_hit[IDX_STOP];

  trig_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_edge  (start_edge),
    .stop_edge   (stop_edge),
    .running     (running),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse)
  );

  p_edge_after_change_r9: assert property (@(posedge clk) disable iff (rst)
    start_edge |=> $past(sync_lines[IDX_START]) == ACTIVE_RISE);

endmodule

// File: tb/trig_window_ctrl_tb.sv
`timescale 1ns/1ps
module trig_window_ctrl_tb;

  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_in = 1'b0;
  logic stop_in = 1'b0;
  logic running, start_pulse, stop_pulse;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  int n_stop = 0;
  int n_both = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_window_ctrl #(.SYNC_DEPTH(DEPTH), .ACTIVE_RISE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .start_in(start_in), .stop_in(stop_in),
    .running(running), .start_pulse(start_pulse), .stop_pulse(stop_pulse)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (start_pulse) n_start++;
      if (stop_pulse)  n_stop++;
      if (start_pulse && stop_pulse) n_both++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int s0, p0;
    bit exp_run;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 running after reset", running, 0);
    check("R2 start_pulse after reset", start_pulse, 0);
    check("R2 stop_pulse after reset", stop_pulse, 0);

    // R1/R3 exact latency: rise before edge k, effect from edge k+DEPTH
    start_in = 1'b1;
    repeat (DEPTH) @(posedge clk);
    @(negedge clk);
    check("R1 no change before latency", running, 0);
    @(negedge clk);
    check("R1 running at latency", running, 1);
    check("R3 start_pulse at latency", start_pulse, 1);
    @(negedge clk);
    check("R3 start_pulse one cycle", start_pulse, 0);
    check("R3 running held", running, 1);

    // R4 repeated start while open
    s0 = n_start;
    start_in = 1'b0; cycles(DEPTH + 3);
    start_in = 1'b1; cycles(DEPTH + 4);
    check("R4 no extra start_pulse", n_start - s0, 0);
    check("R4 running stays", running, 1);

    // R5 stop closes, exact cycle
    stop_in = 1'b1;
    repeat (DEPTH) @(posedge clk);
    @(negedge clk);
    check("R5 still open before latency", running, 1);
    @(negedge clk);
    check("R5 stop_pulse", stop_pulse, 1);
    check("R5 running cleared", running, 0);
    @(negedge clk);
    check("R5 stop_pulse one cycle", stop_pulse, 0);

    // R6 stop edge in idle
    p0 = n_stop; s0 = n_start;
    start_in = 1'b0; stop_in = 1'b0; cycles(DEPTH + 3);
    stop_in = 1'b1; cycles(DEPTH + 4);
    check("R6 no stop_pulse in idle", n_stop - p0, 0);
    check("R6 running stays 0", running, 0);

    // R7 simultaneous rise in idle; R9 falling start later ignored
    stop_in = 1'b0; cycles(DEPTH + 3);
    start_in = 1'b1; stop_in = 1'b1; cycles(DEPTH + 4);
    check("R7 no start_pulse on tie", n_start - s0, 0);
    check("R7 running stays 0 on tie", running, 0);
    stop_in = 1'b0; cycles(DEPTH + 3);
    start_in = 1'b0; cycles(DEPTH + 4);
    check("R9 falling start ignored", n_start - s0, 0);
    check("R9 running after falling", running, 0);

    // R8 new window after halt
    start_in = 1'b1; cycles(DEPTH + 4);
    check("R8 reopen after halt", n_start - s0, 1);
    check("R8 running after reopen", running, 1);
    start_in = 1'b0; cycles(DEPTH + 3);
    check("R9 falling start keeps window", running, 1);

    // Sweep of all rise combinations from both states (R3..R7)
    exp_run = 1'b1;
    for (int i = 0; i < 48; i++) begin
      int code, s_exp, p_exp;
      code = (i * 7 + i / 4) % 4;
      s0 = n_start; p0 = n_stop;
      start_in = 1'b0; stop_in = 1'b0; cycles(DEPTH + 2 + (i % 3));
      start_in = code[0]; stop_in = code[1];
      cycles(DEPTH + 4);
      s_exp = 0; p_exp = 0;
      if (code[1]) begin
        if (exp_run) p_exp = 1;
        exp_run = 1'b0;
      end else if (code[0] && !exp_run) begin
        s_exp = 1;
        exp_run = 1'b1;
      end
      check("R7 sweep running", running, int'(exp_run));
      check("R3 sweep start count", n_start - s0, s_exp);
      check("R5 sweep stop count", n_stop - p0, p_exp);
    end
    check("R10 pulses never together", n_both, 0);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule